// File: doc/BRIEF.md
# Selectable-Ratio Two-Phase Clock Generator

This block divides a fast dot clock by five, six or seven and produces two non-overlapping phase clocks for a processor. It does this with no binary counter. Instead it uses a four-stage shift counter, in the style of a Johnson counter, whose feedback gate depends on the selected ratio. The two phase outputs are decoded straight from pairs of counter stages. Their pulse widths therefore follow the ratio: the low phase of `phi1_n` lasts two dot clocks at divide-by-seven and one dot clock at the other ratios.

The divide ratio comes from a static two-bit `mode` input. The block samples `mode` only while the synchronous active-low reset is held. The ratio cannot change while the counter is running, and a new ratio takes effect only through a fresh reset. The counter state is brought out on `state` so that it can be observed. In `state`, bit 3 is the first stage (A) and bit 0 is the fourth stage (D).

Both phase outputs come from flops. Each flop is loaded from the counter's next state, so the phases change on the same edge as the counter and cannot glitch.

Top module: `twophase_clkgen`

## Requirements
- R1: While `rst_n` is low at a clock edge, the following edge leaves `state` = 0000, `phi1_n` = 1 and `phi2` = 0.
- R2: The first clock edge with `rst_n` high after reset loads `state` = 1000 in every mode.
- R3: In divide-by-7 (mode 00), `state` cycles through 1000, 1100, 1110, 1111, 0111, 0011, 0001 and back to 1000, with the first stage fed by NAND(C, D).
- R4: In divide-by-6 (mode 01), stages A, B and C cycle through 100, 110, 111, 011, 001, 000, with A fed by NOT C. Stage D always holds the previous value of C.
- R5: In divide-by-5 (mode 10), stages A, B and C cycle through 100, 110, 111, 011, 001, with A fed by NAND(B, C). Stage D always holds the previous value of C.
- R6: `phi1_n` is low exactly when stages B (bit 2) and D (bit 0) are both 1. Each cycle it is low for two dot clocks at divide-by-7 and for one dot clock at divide-by-6 and divide-by-5.
- R7: `phi2` is high exactly when stage B is 0 and stage C (bit 1) is 1. It is high for one dot clock per cycle, never while `phi1_n` is low, and always on the dot clock right after `phi1_n`'s low pulse.
- R8: `mode` is sampled only while `rst_n` is low. A change of `mode` while running has no effect on `state` or on the phases.
- R9: Mode encoding 11 behaves as divide-by-7.
- R10: Successive falling edges of `phi1_n` are 7, 6 or 5 dot clocks apart for modes 00, 01 and 10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot clock |
| rst_n | input | 1 | Synchronous reset, active low; also the mode sampling window |
| mode | input | 2 | Ratio select: 00 = /7, 01 = /6, 10 = /5, 11 = /7 |
| phi1_n | output | 1 | First phase clock, active low |
| phi2 | output | 1 | Second phase clock, active high |
| state | output | 4 | Counter stages A (bit 3) to D (bit 0) |

## Verification
The bench builds the block with its default four-stage counter and two-bit mode. Every mode encoding, including the unused one, can therefore be driven through many full cycles. Each cycle's state, phase widths and phase spacing are compared against sequences that the bench derives arithmetically from the position within the cycle. The bench changes `mode` at the moment reset is released and resets again in mid-run. This exercises the first-edge load and checks that `mode` is ignored while the counter runs.

// File: rtl/twophase_clkgen_pkg.sv
// Package: twophase_clkgen_pkg
// Shared constants and the ratio type for the two-phase clock generator.
// Assumes a four-stage counter; phase decode positions depend on it.
package twophase_clkgen_pkg;

    // Number of shift stages in the counter.
    localparam int CTR_W  = 4;
    // Width of the mode selector.
    localparam int MODE_W = 2;

    // Selected divide ratio.
    typedef enum logic [1:0] {
        RATIO_7 = 2'd0,
        RATIO_6 = 2'd1,
        RATIO_5 = 2'd2
    } ratio_e;

    // Map a raw mode code onto a ratio; the spare code falls back to /7.
    function automatic ratio_e decode_mode(input logic [MODE_W-1:0] code);
        ratio_e r;
        case (code)
            2'b01:   r = RATIO_6;
            2'b10:   r = RATIO_5;
            default: r = RATIO_7;
        endcase
        return r;
    endfunction

    // Number of dot clocks in one cycle at a given ratio.
    function automatic int unsigned ratio_period(input ratio_e r);
        int unsigned p;
        case (r)
            RATIO_6: p = 6;
            RATIO_5: p = 5;
            default: p = 7;
        endcase
        return p;
    endfunction

endpackage

// File: rtl/twophase_mode_latch.sv
// Module: twophase_mode_latch
// Captures the ratio selector while reset is held and keeps it for the
// whole run. Assumes the mode input is steady for at least one edge of
// the reset window; any later change is deliberately ignored.
module twophase_mode_latch
    import twophase_clkgen_pkg::*;
#(
    parameter int SEL_W = MODE_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] mode_i,
    output ratio_e           ratio_o
);

    ratio_e ratio_q;

    // Capture the decoded ratio only during reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ratio_q <= decode_mode(mode_i);
        end
    end

    assign ratio_o = ratio_q;

    // R8: the ratio cannot move while the counter runs.
    assert_ratio_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> $stable(ratio_q));

    // R9: the spare code captured in reset selects divide-by-7.
    assert_spare_code_R9: assert property (@(posedge clk)
        (!rst_n && mode_i == 2'b11) |=> (ratio_q == RATIO_7));

endmodule

// File: rtl/twophase_shift_counter.sv
// Module: twophase_shift_counter
// Four-stage shift counter with ratio-dependent feedback into the first
// stage. Bit W-1 is stage A (fed back), bit 0 is stage D. Assumes the
// ratio is constant between resets. Exposes both the present state and
// the next state so that the phase decode can register against it.
module twophase_shift_counter
    import twophase_clkgen_pkg::*;
#(
    parameter int W = CTR_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  ratio_e       ratio_i,
    output logic [W-1:0] state_o,
    output logic [W-1:0] state_d_o
);

    localparam int IDX_A = W - 1;   // first stage
    localparam int IDX_B = W - 2;   // second stage
    localparam int IDX_C = W - 3;   // third stage
    localparam int IDX_D = W - 4;   // fourth stage

    logic [W-1:0] stg_q;
    logic [W-1:0] stg_d;
    logic         fb;

    // Pick the feedback gate for the selected ratio.
    always_comb begin
        case (ratio_i)
            RATIO_6: fb = ~stg_q[IDX_C];
            RATIO_5: fb = ~(stg_q[IDX_B] & stg_q[IDX_C]);
            default: fb = ~(stg_q[IDX_C] & stg_q[IDX_D]);
        endcase
    end

    // Feedback enters the first stage; reset clears everything.
    always_comb begin
        stg_d[IDX_A] = rst_n ? fb : 1'b0;
    end

    // Every later stage copies the stage ahead of it.
    for (genvar i = 0; i < W - 1; i++) begin : g_shift
        always_comb begin
            stg_d[i] = rst_n ? stg_q[i+1] : 1'b0;
        end
    end

    // Advance the counter on each dot clock.
    always_ff @(posedge clk) begin
        stg_q <= stg_d;
    end

    assign state_o   = stg_q;
    assign state_d_o = stg_d;

    // R1: reset leaves the counter empty.
    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (stg_q == '0));

    // R2: from the empty state the first run edge loads the lead state.
    assert_first_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (stg_q == '0) |=> (stg_q == 4'b1000));

    // R3: divide-by-7 stays within its seven legal states.
    assert_div7_legal_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ratio_i == RATIO_7) |-> (stg_q inside {4'b0000, 4'b1000, 4'b1100,
            4'b1110, 4'b1111, 4'b0111, 4'b0011, 4'b0001}));

    // R3: the all-ones state is left by shifting in a zero.
    assert_div7_turn_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ratio_i == RATIO_7 && stg_q == 4'b1111) |=> (stg_q == 4'b0111));

    // R4: divide-by-6 wraps from 000 in stages A to C back to 100.
    assert_div6_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ratio_i == RATIO_6 && stg_q == 4'b0001) |=> (stg_q == 4'b1000));

    // R5: divide-by-5 never reaches 000 in stages A to C once running.
    assert_div5_no_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ratio_i == RATIO_5 && stg_q != 4'b0000) |=> (stg_q[3:1] != 3'b000));

    // R4/R5: stage D is always the previous stage C.
    assert_stage_d_delay_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (stg_q[IDX_D] == $past(stg_q[IDX_C])));

endmodule

// File: rtl/twophase_phase_decode.sv
// Module: twophase_phase_decode
// Produces the two phase clocks from flops loaded with the decode of the
// counter's next state, so phases line up with the state and cannot
// glitch. Assumes it receives stages B, C and D of the next state.
module twophase_phase_decode
    import twophase_clkgen_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] nxt_bcd_i,   // {B, C, D} of the next state
    output logic       phi1_n_o,
    output logic       phi2_o
);

    logic phi1_n_q;
    logic phi2_q;
    logic nb, nc, nd;

    assign nb = nxt_bcd_i[2];
    assign nc = nxt_bcd_i[1];
    assign nd = nxt_bcd_i[0];

    // Register both phases from the next-state decode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phi1_n_q <= 1'b1;
            phi2_q   <= 1'b0;
        end else begin
            phi1_n_q <= ~(nb & nd);
            phi2_q   <= ~nb & nc;
        end
    end

    assign phi1_n_o = phi1_n_q;
    assign phi2_o   = phi2_q;

    // R1: phases idle after a reset edge.
    assert_phase_idle_R1: assert property (@(posedge clk)
        !rst_n |=> (phi1_n_q && !phi2_q));

    // R7: the phases never overlap.
    assert_no_overlap_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !phi1_n_q |-> !phi2_q);

    // R7: phi2 rises only as phi1 ends.
    assert_phi2_follows_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(phi2_q) |-> $rose(phi1_n_q));

    // R7: phi2 lasts a single dot clock.
    assert_phi2_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        phi2_q |=> !phi2_q);

endmodule

// File: rtl/twophase_clkgen.sv
// Module: twophase_clkgen
// Top of the selectable-ratio two-phase clock generator: the mode latch,
// the shift counter and the phase decode. Assumes a free-running dot
// clock and that mode is set up while rst_n is low.
module twophase_clkgen
    import twophase_clkgen_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [MODE_W-1:0] mode,
    output logic              phi1_n,
    output logic              phi2,
    output logic [CTR_W-1:0]  state
);

    ratio_e             ratio;
    logic [CTR_W-1:0]   st_q;
    logic [CTR_W-1:0]   st_d;

    twophase_mode_latch #(.SEL_W(MODE_W)) u_mode (
        .clk     (clk),
        .rst_n   (rst_n),
        .mode_i  (mode),
        .ratio_o (ratio)
    );

    twophase_shift_counter #(.W(CTR_W)) u_ctr (
        .clk       (clk),
        .rst_n     (rst_n),
        .ratio_i   (ratio),
        .state_o   (st_q),
        .state_d_o (st_d)
    );

    twophase_phase_decode u_phase (
        .clk       (clk),
        .rst_n     (rst_n),
        .nxt_bcd_i (st_d[2:0]),
        .phi1_n_o  (phi1_n),
        .phi2_o    (phi2)
    );

    assign state = st_q;

    // R6: phi1 low tracks stages B and D of the visible state.
    assert_phi1_decode_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (phi1_n == !(st_q[2] && st_q[0])));

    // R6: at divide-by-7 a phi1 low pulse lasts at least two dot clocks.
    assert_phi1_wide_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ratio == RATIO_7 && $fell(phi1_n)) |=> !phi1_n);

    // R6: at the shorter ratios the phi1 low pulse lasts one dot clock.
    assert_phi1_narrow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ratio != RATIO_7 && !phi1_n) |=> phi1_n);

endmodule

// File: tb/test_twophase_clkgen.sv
module test_twophase_clkgen;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] mode = 2'b00;
    logic       phi1_n;
    logic       phi2;
    logic [3:0] state;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    twophase_clkgen i_twophase_clkgen (
        .clk    (clk),
        .rst_n  (rst_n),
        .mode   (mode),
        .phi1_n (phi1_n),
        .phi2   (phi2),
        .state  (state)
    );

    always #5 clk = ~clk;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
        end
    endtask

    // Expected {A,B,C} at position p of the cycle for ratio n (A is bit 2).
    function automatic logic [2:0] exp_abc3(input int n, input int p);
        if (p < 3) return 3'((7 << (2 - p)) & 7);
        return 3'(7 >> (p - 2));
    endfunction

    // Expected full state k edges after the lead state, ratio n.
    function automatic logic [3:0] exp_state(input int n, input int k);
        int p;
        logic [2:0] cur;
        logic [2:0] prv;
        p = k % n;
        if (n == 7) begin
            if (p < 4) return 4'((15 << (3 - p)) & 15);
            return 4'(15 >> (p - 3));
        end
        cur = exp_abc3(n, p);
        prv = (k == 0) ? 3'b000 : exp_abc3(n, (p + n - 1) % n);
        return {cur, prv[0]};
    endfunction

    // Reset with mode m, release (optionally flipping mode), then check n_cyc cycles.
    task automatic run_mode(input logic [1:0] m, input int ratio, input int n_cyc,
                            input bit flip, input string rq);
        int low_run;
        int last_fall;
        logic prev_phi1;
        logic [3:0] es;
        @(negedge clk);
        rst_n = 1'b0;
        mode  = m;
        @(negedge clk);
        @(negedge clk);
        chk(state == 4'b0000, "R1 state", state, 0);
        chk(phi1_n == 1'b1, "R1 phi1_n", phi1_n, 1);
        chk(phi2 == 1'b0, "R1 phi2", phi2, 0);
        rst_n = 1'b1;
        if (flip) mode = ~m;   // R8: ignored once running
        low_run   = 0;
        last_fall = -1;
        prev_phi1 = 1'b1;
        for (int k = 0; k < n_cyc; k++) begin
            @(negedge clk);
            if (flip && k == 10) mode = m ^ 2'b01;   // R8: change mid-run
            es = exp_state(ratio, k);
            if (k == 0) chk(state == 4'b1000, "R2 first load", state, 8);
            chk(state == es, rq, state, es);
            chk(phi1_n == !(es[2] && es[0]), "R6 phi1 decode", phi1_n, !(es[2] && es[0]));
            chk(phi2 == (!es[2] && es[1]), "R7 phi2 decode", phi2, !es[2] && es[1]);
            chk(!(phi2 && !phi1_n), "R7 no overlap", phi2, 0);
            if (phi2) chk(prev_phi1 == 1'b0, "R7 phi2 follows phi1", prev_phi1, 0);
            if (!phi1_n) low_run++;
            if (phi1_n && !prev_phi1) begin
                chk(low_run == ((ratio == 7) ? 2 : 1), "R6 phi1 width",
                    low_run, (ratio == 7) ? 2 : 1);
                low_run = 0;
            end
            if (!phi1_n && prev_phi1) begin
                if (last_fall >= 0)
                    chk(k - last_fall == ratio, "R10 phi1 period", k - last_fall, ratio);
                last_fall = k;
            end
            prev_phi1 = phi1_n;
        end
    endtask

    initial begin
        run_mode(2'b00, 7, 50, 1'b0, "R3 div7 sequence");
        run_mode(2'b01, 6, 50, 1'b0, "R4 div6 sequence");
        run_mode(2'b10, 5, 50, 1'b0, "R5 div5 sequence");
        run_mode(2'b11, 7, 50, 1'b0, "R9 spare code as div7");
        run_mode(2'b10, 5, 40, 1'b1, "R8 div5 mode change ignored");
        run_mode(2'b00, 7, 40, 1'b1, "R8 div7 mode change ignored");
        run_mode(2'b01, 6, 13, 1'b0, "R4 div6 short run");
        run_mode(2'b00, 7, 30, 1'b0, "R3 div7 after mid-run reset");
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule